// File: doc/BRIEF.md
# Four-Mode Test Register with Scan and Signature Functions

This block is a clocked register of configurable width that sits between two combinational blocks of a larger design. A two-bit mode input chooses what the register does at each rising clock edge. It can capture its parallel inputs as an ordinary pipeline register. It can act as a serial scan chain. It can clear itself. It can also fold its parallel inputs into a running signature through an XOR-feedback shift structure.

When the parallel inputs are held constant, the signature function runs as a free linear feedback shift register and produces test patterns. A chain of such registers can therefore run alternating test sessions. While one register drives patterns into the next combinational block, the register after that block compacts the responses. Between sessions the chain is seeded, and the signatures are read out, through the scan path.

The mode input is decoded into four named operating states: OP_SHIFT, OP_CLEAR, OP_SIGN and OP_LOAD. Any state may follow any other. A new mode takes effect at the very next clock edge, with no extra latency. The register contents carry over unchanged across a mode change, so a seed loaded in OP_LOAD or OP_SHIFT is the starting point of OP_SIGN.

Top module: `bilbo_reg`

## Requirements
- R1: An active-low reset, asynchronous or seen at a clock edge, forces every register bit to 0, so par_o = 0 and scan_o = 0.
- R2: With mode_i = 2'b00 (OP_SHIFT), each edge moves the contents one place toward the top bit and loads scan_i into bit 0, so the next value is {q[W-2:0], scan_i}.
- R3: With mode_i = 2'b01 (OP_CLEAR), each edge clears all bits to 0, whatever the values on par_i and scan_i.
- R4: With mode_i = 2'b10 (OP_SIGN), bit i (i ≥ 1) takes q[i-1] XOR par_i[i], and bit 0 takes par_i[0] XOR the parity of (q AND TAPS). TAPS is a parameter that defaults to 8'hB8, which selects bits 7, 5, 4 and 3.
- R5: In OP_SIGN with par_i held at 0 and the default W = 8 and TAPS, a nonzero seed never reaches zero and comes back to itself after exactly 255 edges, and not before.
- R6: With mode_i = 2'b11 (OP_LOAD), each edge copies par_i into the register.
- R7: par_o always shows the register contents and scan_o always shows its top bit, W-1, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode select: 00 shift, 01 clear, 10 signature, 11 load |
| par_i | input | W | Parallel data from the upstream combinational block |
| scan_i | input | 1 | Serial scan input into bit 0 |
| par_o | output | W | Register contents to the downstream block |
| scan_o | output | 1 | Serial scan output, register bit W-1 |

## Verification
The hardest behaviour to reach from the ports is the full pattern-generation cycle. It needs a nonzero seed in place before the signature mode runs with constant inputs for 255 consecutive edges. The bench reaches it by loading a seed through OP_LOAD, holding par_i at zero in OP_SIGN, and counting edges until the seed comes back, while checking that zero never appears. Signature compaction is then driven with an input stream that changes on every edge. The bench also shifts every one of the 256 possible byte values through the scan path, so that each bit position carries both 0 and 1 in both directions.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    // Operating states selected by the two mode bits
    typedef enum logic [1:0] {
        OP_SHIFT = 2'b00,
        OP_CLEAR = 2'b01,
        OP_SIGN  = 2'b10,
        OP_LOAD  = 2'b11
    } bilbo_op_e;

endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
    import bilbo_pkg::*;
(
    input  logic [1:0] mode_i,
    output bilbo_op_e  op_o
);

    always_comb begin
        unique case (mode_i)
            2'b00:   op_o = OP_SHIFT;
            2'b01:   op_o = OP_CLEAR;
            2'b10:   op_o = OP_SIGN;
            default: op_o = OP_LOAD;
        endcase
    end

endmodule

// File: rtl/bilbo_shift_next.sv
module bilbo_shift_next #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic         sin_i,
    output logic [W-1:0] nxt_o
);

    assign nxt_o = {cur_i[W-2:0], sin_i};

endmodule

// File: rtl/bilbo_sig_next.sv
module bilbo_sig_next #(
    parameter int unsigned   W    = 8,
    parameter logic [W-1:0]  TAPS = 'hB8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] nxt_o
);

    logic feedback;

    // Parity of the tapped bits feeds the bottom of the chain
    assign feedback = ^(cur_i & TAPS);
    assign nxt_o[0] = par_i[0] ^ feedback;

    for (genvar i = 1; i < W; i++) begin : g_stage
        assign nxt_o[i] = cur_i[i-1] ^ par_i[i];
    end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int unsigned   W    = 8,
    parameter logic [W-1:0]  TAPS = 'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] par_i,
    input  logic         scan_i,
    output logic [W-1:0] par_o,
    output logic         scan_o
);

    localparam int unsigned TOP = W - 1;

    bilbo_op_e    op;
    logic [W-1:0] q;
    logic [W-1:0] q_nxt;
    logic [W-1:0] shift_nxt;
    logic [W-1:0] sig_nxt;

    bilbo_mode_dec u_dec (
        .mode_i (mode_i),
        .op_o   (op)
    );

    bilbo_shift_next #(.W(W)) u_shift (
        .cur_i (q),
        .sin_i (scan_i),
        .nxt_o (shift_nxt)
    );

    bilbo_sig_next #(.W(W), .TAPS(TAPS)) u_sig (
        .cur_i (q),
        .par_i (par_i),
        .nxt_o (sig_nxt)
    );

    // Next-value selection per operating state
    always_comb begin
        unique case (op)
            OP_SHIFT: q_nxt = shift_nxt;
            OP_CLEAR: q_nxt = '0;
            OP_SIGN:  q_nxt = sig_nxt;
            OP_LOAD:  q_nxt = par_i;
            default:  q_nxt = q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // Outputs
    always_comb begin
        par_o  = q;
        scan_o = q[TOP];
    end

endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
    parameter int unsigned   W    = 8,
    parameter logic [W-1:0]  TAPS = 'hB8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_i,
    input logic [W-1:0] par_i,
    input logic         scan_i,
    input logic [W-1:0] par_o,
    input logic         scan_o
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (par_o == '0 && scan_o == 1'b0);
        end
    end

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b00 |=> par_o == {$past(par_o[W-2:0]), $past(scan_i)});

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b01 |=> par_o == '0);

    // R4
    sig_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b10 |=> par_o[W-1:1] == ($past(par_o[W-2:0]) ^ $past(par_i[W-1:1])));

    // R4
    sig_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b10 |=> par_o[0] == ($past(par_i[0]) ^ (^($past(par_o) & TAPS))));

    // R6
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b11 |=> par_o == $past(par_i));

    // R7
    scan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'b00 |=> scan_o == $past(par_o[W-2]));

endmodule

bind bilbo_reg bilbo_reg_chk #(.W(W), .TAPS(TAPS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .par_i  (par_i),
    .scan_i (scan_i),
    .par_o  (par_o),
    .scan_o (scan_o)
);

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [7:0] TAPS = 8'hB8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b11;
    logic [W-1:0] par_i = '0;
    logic         scan_i = 1'b0;
    logic [W-1:0] par_o;
    logic         scan_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] model = '0;

    bilbo_reg #(.W(W), .TAPS(TAPS)) u_bilbo_reg (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .par_i(par_i),
        .scan_i(scan_i), .par_o(par_o), .scan_o(scan_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(input logic [1:0] m, input logic [7:0] p, input logic s);
        mode_i = m;
        par_i  = p;
        scan_i = s;
        @(negedge clk);
    endtask

    function automatic logic [7:0] sig_model(input logic [7:0] q, input logic [7:0] p);
        int fb = 0;
        for (int k = 0; k < 8; k++)
            if (TAPS[k] && q[k]) fb = fb + 1;
        return (8'((int'(q) * 2) % 256)) ^ p ^ 8'(fb % 2);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset par_o", par_o, 8'h00);
        chk("R1 reset scan_o", {7'd0, scan_o}, 8'h00);
        rst_n = 1'b1;

        // R6 / R7 load every value
        for (int v = 0; v < 256; v++) begin
            step(2'b11, 8'(v), 1'b0);
            chk("R6 load", par_o, 8'(v));
            chk("R7 scan_o top bit", {7'd0, scan_o}, {7'd0, v[7]});
        end
        model = 8'hFF;

        // R2 shift every byte value in, MSB first
        for (int v = 0; v < 256; v++) begin
            for (int b = 7; b >= 0; b--) begin
                step(2'b00, 8'hC3, v[b]);
                model = {model[6:0], v[b]};
                chk("R2 shift", par_o, model);
                chk("R7 scan_o in shift", {7'd0, scan_o}, {7'd0, model[7]});
            end
            chk("R2 full byte", par_o, 8'(v));
        end

        // R3 clear ignores par_i and scan_i
        step(2'b11, 8'hFF, 1'b1);
        step(2'b01, 8'hA5, 1'b1);
        chk("R3 clear", par_o, 8'h00);
        chk("R3 clear scan_o", {7'd0, scan_o}, 8'h00);
        step(2'b01, 8'hFF, 1'b1);
        chk("R3 clear held", par_o, 8'h00);

        // R4 signature with a changing input stream
        step(2'b11, 8'h3C, 1'b0);
        model = 8'h3C;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] p;
            p = 8'((i * 37 + 5) % 256);
            step(2'b10, p, 1'b1);
            model = sig_model(model, p);
            chk("R4 signature", par_o, model);
        end

        // R5 pattern generation period
        begin
            int steps = 0;
            bit seen_zero = 0;
            step(2'b11, 8'h01, 1'b0);
            do begin
                step(2'b10, 8'h00, 1'b0);
                steps++;
                if (par_o == 8'h00) seen_zero = 1;
            end while (par_o != 8'h01 && steps < 400);
            chk("R5 period", 8'(steps), 8'd255);
            chk("R5 no zero state", {7'd0, seen_zero}, 8'h00);
        end

        // R1 asynchronous reset between edges
        step(2'b11, 8'h5A, 1'b0);
        chk("R6 load before reset", par_o, 8'h5A);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", par_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b11, 8'h81, 1'b0);
        chk("R6 load after reset", par_o, 8'h81);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule